// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two independent direction components and a chooser. The local component keeps a short outcome history for each branch, selected by PC bits, and uses that history to pick a 2-bit counter. The global component uses a shift register of recent outcomes from all branches to pick its own 2-bit counter. A third table of 2-bit counters is indexed by PC bits XOR the global history. It decides, per branch and history context, which component supplies the final answer.

The predict port is purely combinational: a PC goes in, and the final bit plus both component bits come out in the same cycle. The update port is sampled on the clock edge. It takes the branch PC, the resolved outcome and the two component bits that were produced for that branch at predict time. The bits are returned because the chooser trains on whether the components disagreed. History is updated non-speculatively at update time, so callers issue the update for a branch before predicting the next one that must observe it.

Every counter in the block is one small state machine with four named states: CTR_SNT (0), CTR_WNT (1), CTR_WT (2) and CTR_ST (3). It has three named transitions. "climb" moves one state up on a taken (or "favour global") input. "fall" moves one state down on the opposite input. "hold" keeps CTR_SNT on fall and CTR_ST on climb.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter is CTR_WNT (1) and all histories are zero, so pred_local, pred_global and pred_taken are all 0 for any PC and the chooser selects the local component.
- R2: A counter that is trained climbs one state on taken and falls one state on not-taken, holding at CTR_ST (3) and CTR_SNT (0).
- R3: A component predicts taken exactly when its counter is in state 2 or 3, and not-taken in states 0 or 1.
- R4: The local component reads the per-branch history entry at pred_pc[PC_LSB +: LHT_IDX_W], and that history selects the local counter. At update the entry for upd_pc shifts upd_taken into bit 0, keeping LHIST_W bits.
- R5: The global component's counter is selected by the global history. Each update shifts upd_taken into bit 0 of the global history, keeping GHIST_W bits.
- R6: The chooser counter at pred_pc[PC_LSB +: CH_IDX_W] XOR global history selects global in states 2 or 3 and local in states 0 or 1. pred_taken equals the selected component's bit.
- R7: When upd_local differs from upd_global, the chooser counter at upd_pc's index climbs if upd_global equals upd_taken, and falls otherwise.
- R8: When upd_local equals upd_global, the chooser counter is left unchanged.
- R9: Every update trains both the local and the global counter it indexes with upd_taken, whatever the chooser selects.
- R10: With upd_valid low, no counter or history changes, whatever the other update inputs carry.
- R11: With default parameters, a single branch that repeats taken four times then not-taken once settles at exactly one local-component mispredict per five executions. The final prediction settles at no mispredicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final prediction chosen by the chooser |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| upd_valid | input | 1 | Apply an update on this edge |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_local | input | 1 | Local bit given for this branch at predict time |
| upd_global | input | 1 | Global bit given for this branch at predict time |

## Verification
The hardest situation to reach from the ports is a chooser counter climbing all the way into the global-selecting states. That needs repeated disagreements in which only the global side is right, and every one of them must land on the same chooser entry. Because the chooser index mixes in the global history, the stimulus uses a periodic loop pattern on one branch. This keeps the history at the not-taken position identical in every period. The short local history then keeps failing there while the global counters learn it. A bench-side reference model, driven from the requirements, predicts each output for every branch as the counters and histories evolve.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    // climb on up, fall otherwise, hold at both ends
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        unique case (cur)
            CTR_SNT: nxt = up ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = up ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = up ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = up ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return (cur == CTR_WT) || (cur == CTR_ST);
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_st,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];
    ctr_t wr_next;

    always_comb begin
        wr_next = ctr_step(ctr_q[wr_idx], wr_up);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_WNT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_next;
        end
    end

    always_comb begin
        rd_st = ctr_q[rd_idx];
    end

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic [IDX_W-1:0]  up_idx,
    output logic [HIST_W-1:0] up_hist,
    input  logic              up_en,
    input  logic              up_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (up_en) begin
            hist_q[up_idx] <= HIST_W'({hist_q[up_idx], up_bit});
        end
    end

    always_comb begin
        rd_hist = hist_q[rd_idx];
        up_hist = hist_q[up_idx];
    end

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
    import tp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int LHT_IDX_W = 4,
    parameter int LHIST_W   = 2,
    parameter int GHIST_W   = 6,
    parameter int CH_IDX_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local,
    input  logic            upd_global
);
    logic [GHIST_W-1:0]   ghist;
    logic [LHT_IDX_W-1:0] p_lht_idx, u_lht_idx;
    logic [LHIST_W-1:0]   p_lhist, u_lhist;
    logic [CH_IDX_W-1:0]  p_ch_idx, u_ch_idx;
    ctr_t                 lcl_st, glb_st, choose_st;
    logic                 ch_train, ch_up;
    logic                 unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc, upd_pc};

    always_comb begin
        p_lht_idx = pred_pc[PC_LSB +: LHT_IDX_W];
        u_lht_idx = upd_pc[PC_LSB +: LHT_IDX_W];
        p_ch_idx  = pred_pc[PC_LSB +: CH_IDX_W] ^ CH_IDX_W'(ghist);
        u_ch_idx  = upd_pc[PC_LSB +: CH_IDX_W] ^ CH_IDX_W'(ghist);
        ch_train  = upd_valid && (upd_local != upd_global);
        ch_up     = (upd_global == upd_taken);
    end

    tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (p_lht_idx),
        .rd_hist (p_lhist),
        .up_idx  (u_lht_idx),
        .up_hist (u_lhist),
        .up_en   (upd_valid),
        .up_bit  (upd_taken)
    );

    tp_ctr_table #(.IDX_W(LHIST_W)) u_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (p_lhist),
        .rd_st  (lcl_st),
        .wr_en  (upd_valid),
        .wr_idx (u_lhist),
        .wr_up  (upd_taken)
    );

    tp_ctr_table #(.IDX_W(GHIST_W)) u_global (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (ghist),
        .rd_st  (glb_st),
        .wr_en  (upd_valid),
        .wr_idx (ghist),
        .wr_up  (upd_taken)
    );

    tp_ctr_table #(.IDX_W(CH_IDX_W)) u_chooser (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (p_ch_idx),
        .rd_st  (choose_st),
        .wr_en  (ch_train),
        .wr_idx (u_ch_idx),
        .wr_up  (ch_up)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist <= '0;
        end else if (upd_valid) begin
            ghist <= GHIST_W'({ghist, upd_taken});
        end
    end

    always_comb begin
        pred_local  = ctr_says_taken(lcl_st);
        pred_global = ctr_says_taken(glb_st);
        pred_taken  = choose_st[1] ? pred_global : pred_local;
    end

endmodule

// File: rtl/tp_checker.sv
module tp_checker
    import tp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int GHIST_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pred_pc,
    input logic               pred_taken,
    input logic               pred_local,
    input logic               pred_global,
    input logic               upd_valid,
    input logic               upd_taken,
    input ctr_t               choose_st,
    input logic [GHIST_W-1:0] ghist
);
    AST_SEL_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (choose_st == CTR_WT || choose_st == CTR_ST) |-> (pred_taken == pred_global)); // R6
    AST_SEL_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (choose_st == CTR_SNT || choose_st == CTR_WNT) |-> (pred_taken == pred_local)); // R6
    AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[0] == $past(upd_taken))); // R5
    AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghist)); // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (!$stable(pred_pc) || $stable({pred_taken, pred_local, pred_global}))); // R10
endmodule

bind tourney_predictor tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (.*);

// File: tb/test_tourney_predictor.sv
module test_tourney_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_local, pred_global;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;

    tourney_predictor i_tourney_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_local(upd_local), .upd_global(upd_global)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit    t;
        bit    l;
        bit    g;
        string tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   got_t, got_l;

    // reference model state
    int lh[16];
    int lc[4];
    int gc[64];
    int cc[64];
    int gh;

    function automatic int sat(input int v, input bit up);
        if (up) return (v == 3) ? 3 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic model_reset();
        foreach (lh[i]) lh[i] = 0;
        foreach (lc[i]) lc[i] = 1;
        foreach (gc[i]) gc[i] = 1;
        foreach (cc[i]) cc[i] = 1;
        gh = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
    endtask

    // driver: predict, push expectation, then update
    task automatic do_branch(input int pc, input bit t, input string tag);
        int  li, ci;
        bit  el, eg, et;
        exp_t e;
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pc;
        li = (pc >> 2) & 15;
        ci = ((pc >> 2) & 63) ^ gh;
        el = lc[lh[li]] >= 2;
        eg = gc[gh] >= 2;
        et = (cc[ci] >= 2) ? eg : el;
        #1;
        e.t = et; e.l = el; e.g = eg; e.tag = tag;
        q.push_back(e);
        -> chk_ev;
        got_t = pred_taken;
        got_l = pred_local;
        upd_pc = pc;
        upd_taken = t;
        upd_local = el;
        upd_global = eg;
        upd_valid = 1'b1;
        lc[lh[li]] = sat(lc[lh[li]], t);
        gc[gh] = sat(gc[gh], t);
        if (el != eg) cc[ci] = sat(cc[ci], eg == t);
        lh[li] = ((lh[li] << 1) | int'(t)) & 3;
        gh = ((gh << 1) | int'(t)) & 63;
    endtask

    task automatic check_val(input int got, input int exp, input string tag);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // monitor: pop and compare
    initial begin
        exp_t e;
        forever begin
            @(chk_ev);
            e = q.pop_front();
            n_cmp++;
            if ({pred_taken, pred_local, pred_global} != {e.t, e.l, e.g}) begin
                n_bad++;
                $display("FAIL %s: got t/l/g=%b%b%b expected %b%b%b", e.tag,
                         pred_taken, pred_local, pred_global, e.t, e.l, e.g);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lfsr;
        int miss_l, miss_t;
        model_reset();
        do_reset();

        // R1: reset state seen on several PCs (no training between reads)
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            pred_pc = 32'h100 + 32'(k * 52);
            #1;
            check_val(int'({pred_taken, pred_local, pred_global}), 0, "R1");
            @(negedge clk);
        end

        // R8: first branches agree (both NT) so chooser stays put
        do_branch(32'h40, 1'b1, "R8");
        do_branch(32'h44, 1'b1, "R8");
        // R2/R3: saturate up then down on one PC
        for (int k = 0; k < 8; k++) do_branch(32'h20, 1'b1, "R2/R3");
        for (int k = 0; k < 8; k++) do_branch(32'h20, 1'b0, "R2/R3");
        // R4/R5/R7/R9: mixed PCs and outcomes
        lfsr = 32'h1ace;
        for (int k = 0; k < 300; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
            do_branch((lfsr & 32'h3c) + ((k % 3) * 32'h100), lfsr[5] ^ lfsr[9],
                      (k % 2 == 0) ? "R4/R9" : "R5/R7");
        end

        // R10: garbage on update inputs with upd_valid low
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc = 32'(k * 4);
            upd_taken = k[0];
            upd_local = k[1];
            upd_global = ~k[0];
        end
        for (int k = 0; k < 6; k++) do_branch(32'(k * 4), 1'b1, "R10");

        // R11: loop pattern on a fresh predictor
        do_reset();
        miss_l = 0;
        miss_t = 0;
        for (int p = 0; p < 20; p++) begin
            for (int s = 0; s < 5; s++) begin
                do_branch(32'h80, s != 4, "R11");
                if (p >= 15) begin
                    if (got_l != (s != 4)) miss_l++;
                    if (got_t != (s != 4)) miss_t++;
                end
            end
        end
        check_val(miss_l, 5, "R11 local mispredicts");
        check_val(miss_t, 0, "R6/R7 final mispredicts");

        @(negedge clk);
        upd_valid = 1'b0;
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule